// File: doc/BRIEF.md
# Continuous Edge Time-Stamping Engine

This block places user-signal edges on a shared time axis. It is clocked by the reference clock and keeps two running counts from one common baseline. The first count is the number of reference periods. The second is the number of user edges. The edge detector in front of the block reports at most one edge per reference period, on the `evt` input. The edge is reported in the period where it happened, so the reference edge that samples `evt` is the first reference edge after the user edge.

Some edges are chosen for measurement. The choice uses only the running edge index, so measurement starts at once, with no locking phase. For each chosen edge the block latches the period count at that following reference edge. It then asks an external interpolator for the fine delta, which is the time from the user edge to that reference edge. The delta comes back as an unsigned fraction where 4096 equals one period. The block subtracts it from the latched count to form a fixed-point time stamp with a 32-bit integer part and a 12-bit fraction. Each result leaves the block as an (event index, stamp) record on a valid/ready stream.

Edges waiting for their delta are held in a 4-entry pending queue. Finished records wait in a 4-entry output queue. When there is no room, the record is dropped and a sticky flag is set. The counters never stop.

Top module: `edge_stamper`

## Requirements
- R1: A `start` pulse marks the baseline. The reference edge that samples it is time 0. That edge clears both counts, both queues and `ovf`, and loads the selection settings. Synchronous `rst` has the same effect, with all selection settings at zero.
- R2: User edges are numbered from 0. The first edge reported after the baseline has index 0, and each later edge has the next index. This holds whether or not the edge is selected, dropped or measured.
- R3: An edge is selected when its index equals `sel_first + k*stride` for some k in 0 to `sel_count-1`. A stride of 0 counts as 1. A count of 0 selects nothing.
- R4: Let k be the number of reference edges from time 0 up to the edge that samples `evt`. The time stamp is k*4096 minus the fine value. It is an unsigned 44-bit number: integer periods in bits 43:12 and fraction in bits 11:0.
- R5: A selected edge that is accepted raises `fine_req` for exactly one cycle, in the cycle after it is sampled. Fine values are consumed in acceptance order, one per `fine_valid && fine_ready` handshake. `fine_ready` is high only while a measurement is pending and the output queue has room.
- R6: Records leave in selection order. While `rec_valid` is high and `rec_ready` is low, the record does not change.
- R7: If a selected edge arrives while the pending queue or the output queue is full, its record is dropped and `ovf` goes high. `ovf` stays high until the next baseline. Counting goes on, so later records keep their true indices and stamps.
- R8: Counting goes on across measurements. All records from one acquisition share one baseline, and the edge with index 0 can be measured straight away.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Baseline pulse; clears counts, queues and flag |
| sel_first | input | 32 | Index of the first edge to measure |
| sel_stride | input | 32 | Index step between measured edges (0 means 1) |
| sel_count | input | 32 | Number of edges to select |
| evt | input | 1 | One user edge occurred in the current reference period |
| fine_req | output | 1 | One-cycle request to the interpolator for an accepted edge |
| fine_valid | input | 1 | Fine delta available |
| fine_data | input | 12 | Edge-to-next-reference delta, 4096 = one period |
| fine_ready | output | 1 | Block takes a fine delta this cycle |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer takes the record |
| rec_index | output | 32 | Event index of the record |
| rec_stamp | output | 44 | Time stamp, 32.12 fixed point |
| ovf | output | 1 | Sticky: a selected record was dropped |

## Verification
The hardest state to reach is a drop with full queues, followed by proof that the counts did not slip. The stimulus first withholds fine values and blocks the consumer. It then sends a run of selected edges in back-to-back periods, so the pending queue fills and the last two are dropped. It then releases the interpolator and the consumer. Next it sends one more selected edge and checks that this edge's record carries its true index and an accurate stamp while `ovf` stays set. Random rounds mix edge spacing, strides and handshake stalls, and compare every stamp with the ideal edge time to within one fraction LSB.

// File: rtl/edge_stamper.sv
module edge_stamper #(
  parameter int CW = 32,
  parameter int FW = 12,
  parameter int IW = 32,
  parameter int PD = 4,
  parameter int OD = 4
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IW-1:0]    sel_first,
  input  logic [IW-1:0]    sel_stride,
  input  logic [IW-1:0]    sel_count,
  input  logic             evt,
  output logic             fine_req,
  input  logic             fine_valid,
  input  logic [FW-1:0]    fine_data,
  output logic             fine_ready,
  output logic             rec_valid,
  input  logic             rec_ready,
  output logic [IW-1:0]    rec_index,
  output logic [CW+FW-1:0] rec_stamp,
  output logic             ovf
);
  localparam int PW = $clog2(PD);
  localparam int OW = $clog2(OD);
  localparam int SW = CW + FW;

  logic [CW-1:0] per_cnt;
  logic [IW-1:0] ev_cnt, next_sel, left;

  logic [IW-1:0] p_idx [PD];
  logic [CW-1:0] p_crs [PD];
  logic [PW-1:0] p_wp, p_rp;
  logic [PW:0]   p_n;

  logic [IW-1:0] o_idx   [OD];
  logic [SW-1:0] o_stamp [OD];
  logic [OW-1:0] o_wp, o_rp;
  logic [OW:0]   o_n;

  logic [IW-1:0] step;
  logic [SW-1:0] stamp_new;
  logic sel_hit, accept, take, pop_o, p_full, o_full;

  assign step       = (sel_stride == '0) ? IW'(1) : sel_stride;
  assign p_full     = (p_n == (PW+1)'(PD));
  assign o_full     = (o_n == (OW+1)'(OD));
  assign sel_hit    = evt && (left != '0) && (ev_cnt == next_sel);
  assign accept     = sel_hit && !p_full && !o_full;
  assign fine_ready = (p_n != '0) && !o_full;
  assign take       = fine_valid && fine_ready;
  assign rec_valid  = (o_n != '0);
  assign pop_o      = rec_valid && rec_ready;
  assign rec_index  = o_idx[o_rp];
  assign rec_stamp  = o_stamp[o_rp];
  assign stamp_new  = {p_crs[p_rp], {FW{1'b0}}} - {{CW{1'b0}}, fine_data};

  always_ff @(posedge clk) begin
    if (rst || start) begin
      per_cnt  <= '0;
      ev_cnt   <= '0;
      next_sel <= rst ? '0 : sel_first;
      left     <= rst ? '0 : sel_count;
      p_wp     <= '0;
      p_rp     <= '0;
      p_n      <= '0;
      o_wp     <= '0;
      o_rp     <= '0;
      o_n      <= '0;
      ovf      <= 1'b0;
      fine_req <= 1'b0;
    end else begin
      per_cnt  <= per_cnt + 1'b1;
      fine_req <= accept;
      if (evt) ev_cnt <= ev_cnt + 1'b1;
      if (sel_hit) begin
        next_sel <= next_sel + step;
        left     <= left - 1'b1;
        if (!accept) ovf <= 1'b1;
      end
      if (accept) begin
        p_idx[p_wp] <= ev_cnt;
        p_crs[p_wp] <= per_cnt + 1'b1;
        p_wp        <= p_wp + 1'b1;
      end
      if (take) begin
        o_idx[o_wp]   <= p_idx[p_rp];
        o_stamp[o_wp] <= stamp_new;
        o_wp          <= o_wp + 1'b1;
        p_rp          <= p_rp + 1'b1;
      end
      if (pop_o) o_rp <= o_rp + 1'b1;
      p_n <= p_n + (PW+1)'(accept) - (PW+1)'(take);
      o_n <= o_n + (OW+1)'(take) - (OW+1)'(pop_o);
    end
  end
endmodule

// File: rtl/edge_stamper_chk.sv
module edge_stamper_chk #(
  parameter int IW = 32,
  parameter int SW = 44
)(
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          evt,
  input logic          fine_req,
  input logic          fine_ready,
  input logic          rec_valid,
  input logic          rec_ready,
  input logic [IW-1:0] rec_index,
  input logic [SW-1:0] rec_stamp,
  input logic          ovf
);
  p_baseline_clear_r1: assert property (@(posedge clk) disable iff (rst)
    start |=> (!rec_valid && !ovf && !fine_ready && !fine_req));

  p_req_after_edge_r5: assert property (@(posedge clk) disable iff (rst)
    fine_req |-> $past(evt));

  p_record_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && !rec_ready && !start) |=>
      (rec_valid && $stable(rec_index) && $stable(rec_stamp)));

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (ovf && !start) |=> ovf);

  p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> $past(evt));
endmodule

bind edge_stamper edge_stamper_chk #(.IW(IW), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .evt(evt), .fine_req(fine_req),
  .fine_ready(fine_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_index(rec_index), .rec_stamp(rec_stamp), .ovf(ovf)
);

// File: tb/edge_stamper_test.sv
module edge_stamper_test;
  localparam int TCLK = 10;

  logic clk = 0, rst = 1, start = 0, evt = 0;
  logic [31:0] sel_first = 0, sel_stride = 0, sel_count = 0;
  logic fine_req, fine_valid = 0, fine_ready, rec_valid, rec_ready = 0, ovf;
  logic [11:0] fine_data = 0;
  logic [31:0] rec_index;
  logic [43:0] rec_stamp;

  edge_stamper uut (
    .clk(clk), .rst(rst), .start(start), .sel_first(sel_first),
    .sel_stride(sel_stride), .sel_count(sel_count), .evt(evt),
    .fine_req(fine_req), .fine_valid(fine_valid), .fine_data(fine_data),
    .fine_ready(fine_ready), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_index(rec_index), .rec_stamp(rec_stamp), .ovf(ovf)
  );

  always #(TCLK/2) clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  int per = 0, bidx = 0, exp_wr = 0, served = 0, reqs = 0, rec_rd = 0;
  int cfg_s = 0, cfg_d = 1, cfg_n = 0;
  bit drop_mode = 0, fine_en = 0, rec_en = 0, fine_rand = 0, rdy_rand = 0;
  int     exp_idx [64];
  longint exp_t16 [64];
  int     exp_fine[64];

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit is_sel(input int idx, input int s, input int d, input int n);
    int de = (d == 0) ? 1 : d;
    if (idx < s) return 0;
    if ((idx - s) % de != 0) return 0;
    return ((idx - s) / de) < n;
  endfunction

  function automatic int fine_of(input int f16);
    int v = ((65536 - f16) + 8) >>> 4;
    return (v > 4095) ? 4095 : v;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (fine_req) reqs++;
    fine_valid = fine_en && (served < reqs) && (served < exp_wr) && (!fine_rand || ($urandom % 2 == 0));
    fine_data  = fine_valid ? 12'(exp_fine[served]) : 12'd0;
    if (fine_valid && fine_ready) served++;
    rec_ready = rec_en && (!rdy_rand || ($urandom % 2 == 0));
    if (rec_valid && rec_ready) begin
      if (rec_rd < exp_wr) begin
        longint d16 = longint'(rec_stamp) * 16 - exp_t16[rec_rd];
        chk(rec_index == 32'(exp_idx[rec_rd]), "R2 index", rec_index, exp_idx[rec_rd]);
        chk(d16 <= 16 && d16 >= -16, "R4 stamp", longint'(rec_stamp) * 16, exp_t16[rec_rd]);
      end else
        chk(0, "R6 extra record", rec_index, -1);
      rec_rd++;
    end
  end

  task automatic tick();
    @(negedge clk);
    per++;
  endtask

  task automatic do_start(input int s, input int d, input int n);
    cfg_s = s; cfg_d = d; cfg_n = n;
    bidx = 0; exp_wr = 0; served = 0; reqs = 0; rec_rd = 0; drop_mode = 0;
    sel_first = s; sel_stride = d; sel_count = n;
    start = 1;
    @(negedge clk);
    start = 0;
    per = 0;
    chk(!rec_valid && !ovf && !fine_ready, "R1 baseline clear", {rec_valid, ovf, fine_ready}, 0);
  endtask

  task automatic edge_at(input int f16);
    if (is_sel(bidx, cfg_s, cfg_d, cfg_n) && !drop_mode) begin
      exp_idx[exp_wr]  = bidx;
      exp_t16[exp_wr]  = longint'(per) * 65536 + f16;
      exp_fine[exp_wr] = fine_of(f16);
      exp_wr++;
    end
    bidx++;
    evt = 1;
    tick();
    evt = 0;
  endtask

  task automatic drain();
    fine_en = 1; rec_en = 1; fine_rand = 0; rdy_rand = 0;
    repeat (24) tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(!rec_valid && !ovf && !fine_ready && !fine_req, "R1 reset state",
        {rec_valid, ovf, fine_ready, fine_req}, 0);

    // R8: measure from index 0 at once; R4 fraction corners
    do_start(0, 1, 3);
    fine_en = 1; rec_en = 1;
    edge_at(16'h4000);
    edge_at(16'hFFF0);
    tick();
    edge_at(1);
    edge_at(16'h8000);
    drain();
    chk(rec_rd == 3, "R8 immediate records", rec_rd, 3);
    chk(reqs == 3, "R5 one request per accepted edge", reqs, 3);
    chk(!ovf, "R7 no overflow", ovf, 0);

    // R3: stride 0 acts as 1
    do_start(2, 0, 2);
    repeat (6) edge_at(16'h2345);
    drain();
    chk(rec_rd == 2, "R3 stride zero", rec_rd, 2);

    // R3: count 0 selects nothing
    do_start(0, 1, 0);
    repeat (5) edge_at(16'h1000);
    drain();
    chk(reqs == 0, "R3 count zero requests", reqs, 0);
    chk(rec_rd == 0, "R3 count zero records", rec_rd, 0);

    // R7: fill pending queue, drop two, counting continues
    do_start(0, 1, 8);
    fine_en = 0; rec_en = 0;
    chk(!fine_ready, "R5 ready low when idle", fine_ready, 0);
    repeat (4) edge_at(16'h3000 + 16'(per) * 16'h100);
    drop_mode = 1;
    edge_at(16'h5000);
    edge_at(16'h6000);
    drop_mode = 0;
    tick();
    chk(ovf, "R7 overflow set", ovf, 1);
    chk(reqs == 4, "R7 dropped edges not requested", reqs, 4);
    chk(fine_ready, "R5 ready with pending work", fine_ready, 1);
    fine_en = 1;
    repeat (10) tick();
    chk(rec_valid && rec_rd == 0, "R6 records held", rec_rd, 0);
    chk(!fine_ready, "R5 ready low when output full", fine_ready, 0);
    rec_en = 1;
    repeat (10) tick();
    chk(rec_rd == 4, "R6 held records delivered", rec_rd, 4);
    edge_at(16'h7777);
    drain();
    chk(rec_rd == 5, "R7 counting continued after drop", rec_rd, 5);
    chk(ovf, "R7 overflow sticky", ovf, 1);
    do_start(0, 1, 0);
    tick();
    chk(!ovf, "R1 baseline clears overflow", ovf, 0);

    // random rounds
    for (int r = 0; r < 4; r++) begin
      do_start(int'($urandom % 5), 1 + int'($urandom % 3), 6 + int'($urandom % 5));
      fine_en = 1; rec_en = 1; fine_rand = 1; rdy_rand = 1;
      for (int p = 0; p < 90; p++) begin
        if ($urandom % 4 == 0) edge_at(1 + int'($urandom % 65535));
        else tick();
      end
      drain();
      chk(rec_rd == exp_wr, "R3 random record count", rec_rd, exp_wr);
      chk(!ovf, "R7 random no overflow", ovf, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule